// File: doc/BRIEF.md
# Way-Lockable Cache Allocation Controller

This block chooses where a second-level cache line goes. It works on a cache with four ways per set. On each request it takes the lookup result for one set: a one-hot hit vector, the per-way valid bits, the request kind (instruction fetch or data access), a 4-bit way lock mask and a fetch-only mode bit. One cycle later it returns a registered decision. The decision is one of three things: a hit, an allocation into a chosen victim way, or a bypass in which the line is not kept in this cache.

Replacement uses a 3-bit pseudo-LRU tree for each set. Locked ways are never chosen for replacement, but they still report hits. This lets software keep critical code or tables resident. In fetch-only mode, data traffic is never allocated and does not touch the replacement state, so instruction lines cannot be pushed out by loads and stores.

Top module: `cache_way_alloc`

## Requirements
- R1: Every cycle with `req_valid` high produces `dec_valid` high on the next cycle and only then. A synchronous reset clears `dec_valid` and sets every set's tree to 3'b000.
- R2: A request whose `hit_way` (one-hot, bit i = way i) is nonzero and that is not blocked by R7 gives `dec_hit`=1, `dec_allocate`=0 and `dec_bypass`=0, with `victim_way` equal to the index of the hit way.
- R3: A way whose `lock_mask` bit is set is never returned as the victim of an allocation.
- R4: On an allocating miss, if any unlocked way has its valid bit clear, the victim is the lowest-numbered such way.
- R5: Otherwise the tree picks the victim. Tree bit 0 = 0 selects ways 0/1, and then bit 1 picks way 0 (0) or way 1 (1). Tree bit 0 = 1 selects ways 2/3, and then bit 2 picks way 2 (0) or way 3 (1). If the tree points at a locked way, the lowest-numbered unlocked way is taken instead.
- R6: A hit and an allocation both mark the way as most recently used. For way 0 this sets bit0=1 and bit1=1, for way 1 bit0=1 and bit1=0, for way 2 bit0=0 and bit2=1, and for way 3 bit0=0 and bit2=0. The other bit is left unchanged.
- R7: With `fetch_only` high, a data request (`req_is_fetch`=0) gives `dec_bypass`=1 and `dec_allocate`=0 and leaves the tree untouched. `dec_hit` still shows the lookup result, and `victim_way` is the hit way, or 0 on a miss. Fetch requests in this mode behave normally.
- R8: A miss with all four lock bits set gives `dec_no_alloc`=1, `dec_bypass`=1 and `victim_way`=0, and leaves the tree untouched.
- R9: A new lock mask applies from the very next request. A hit on a locked way is still reported as a normal hit.
- R10: Each set keeps its own tree. A request changes only the tree of `req_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_set | input | SET_W | Set index of the request |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| hit_way | input | 4 | One-hot hit vector from the tag compare |
| way_valid | input | 4 | Valid bit of each way in the set |
| lock_mask | input | 4 | 1 = way locked against replacement |
| fetch_only | input | 1 | Fetch-only allocation mode |
| dec_valid | output | 1 | Decision valid |
| dec_hit | output | 1 | Lookup hit |
| dec_allocate | output | 1 | Fill the victim way |
| dec_bypass | output | 1 | Do not keep the line in this cache |
| dec_no_alloc | output | 1 | Miss with every way locked |
| victim_way | output | 2 | Victim way or hit way index |

## Verification
Fixed sequences on one set first walk the tree from reset. They show that tree order and most-recently-used updates are correct, and that a locked target falls back to the lowest unlocked way instead of the next one in tree order. Further sequences place a fetch-only data miss between two fetch misses; the victim of the second miss shows whether the data access left the tree alone. Other short sequences cover full locking, an invalid way among locked ones, a hit on a locked way, and two neighbouring sets, which tells apart the invalid-first choice, the lock handling and per-set storage. A long random stream over four sets then mixes lock masks, valid patterns, hit and miss, and both modes, and compares every field against a model of the trees kept in the bench.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int TREE_W = WAYS - 1;

  typedef logic [WAYS-1:0]   waymask_t;
  typedef logic [WAY_W-1:0]  wayidx_t;
  typedef logic [TREE_W-1:0] tree_t;

  typedef struct packed {
    logic    hit;
    logic    allocate;
    logic    bypass;
    logic    no_alloc;
    wayidx_t way;
    logic    touch;
  } decision_t;

  // way the tree currently names as least recently used
  function automatic wayidx_t tree_target(tree_t t);
    if (t[0]) return t[2] ? wayidx_t'(3) : wayidx_t'(2);
    else      return t[1] ? wayidx_t'(1) : wayidx_t'(0);
  endfunction

  // make way w most recently used: bits point away from it
  function automatic tree_t tree_touch(tree_t t, wayidx_t w);
    tree_t n;
    n = t;
    if (w[1] == 1'b0) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic wayidx_t lowest_set(waymask_t m);
    wayidx_t r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (m[i]) r = wayidx_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/cwa_tree_store.sv
module cwa_tree_store
  import cwa_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output tree_t            rd_tree,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  tree_t            wr_tree
);
  localparam int SETS = 1 << SET_W;

  tree_t mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_set] <= wr_tree;
    end
  end

  assign rd_tree = mem[rd_set];

  // R10: a write changes only the addressed entry
  a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem[$past(wr_set)] == $past(wr_tree)));
endmodule

// File: rtl/cwa_victim_pick.sv
module cwa_victim_pick
  import cwa_pkg::*;
(
  input  tree_t    tree,
  input  waymask_t way_valid,
  input  waymask_t lock_mask,
  output logic     has_free,
  output wayidx_t  victim
);
  waymask_t open_m;
  waymask_t empty_m;
  wayidx_t  target;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign open_m[g]  = ~lock_mask[g];
    assign empty_m[g] = ~lock_mask[g] & ~way_valid[g];
  end

  assign target   = tree_target(tree);
  assign has_free = |open_m;

  always_comb begin
    if (|empty_m)          victim = lowest_set(empty_m);
    else if (open_m[target]) victim = target;
    else                   victim = lowest_set(open_m);
  end

  // R3: whenever a free way exists, the pick is unlocked
  always_comb begin
    if (has_free) a_r3_pick_unlocked: assert (!lock_mask[victim]);
  end
endmodule

// File: rtl/cwa_decide.sv
module cwa_decide
  import cwa_pkg::*;
(
  input  logic      is_fetch,
  input  logic      fetch_only,
  input  waymask_t  hit_way,
  input  logic      has_free,
  input  wayidx_t   pick,
  output decision_t dec
);
  logic    is_hit;
  logic    blocked;
  wayidx_t hit_idx;

  assign is_hit  = |hit_way;
  assign blocked = fetch_only & ~is_fetch;
  assign hit_idx = lowest_set(hit_way);

  always_comb begin
    dec = '0;
    dec.hit = is_hit;
    if (blocked) begin
      dec.bypass = 1'b1;
      dec.way    = is_hit ? hit_idx : '0;
    end else if (is_hit) begin
      dec.way   = hit_idx;
      dec.touch = 1'b1;
    end else if (has_free) begin
      dec.allocate = 1'b1;
      dec.way      = pick;
      dec.touch    = 1'b1;
    end else begin
      dec.no_alloc = 1'b1;
      dec.bypass   = 1'b1;
    end
  end
endmodule

// File: rtl/cache_way_alloc.sv
module cache_way_alloc
  import cwa_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_is_fetch,
  input  logic [3:0]       hit_way,
  input  logic [3:0]       way_valid,
  input  logic [3:0]       lock_mask,
  input  logic             fetch_only,
  output logic             dec_valid,
  output logic             dec_hit,
  output logic             dec_allocate,
  output logic             dec_bypass,
  output logic             dec_no_alloc,
  output logic [1:0]       victim_way
);
  tree_t     cur_tree;
  logic      has_free;
  wayidx_t   pick;
  decision_t dec;

  cwa_tree_store #(.SET_W(SET_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_set  (req_set),
    .rd_tree (cur_tree),
    .wr_en   (req_valid & dec.touch),
    .wr_set  (req_set),
    .wr_tree (tree_touch(cur_tree, dec.way))
  );

  cwa_victim_pick u_pick (
    .tree      (cur_tree),
    .way_valid (way_valid),
    .lock_mask (lock_mask),
    .has_free  (has_free),
    .victim    (pick)
  );

  cwa_decide u_decide (
    .is_fetch   (req_is_fetch),
    .fetch_only (fetch_only),
    .hit_way    (hit_way),
    .has_free   (has_free),
    .pick       (pick),
    .dec        (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid    <= 1'b0;
      dec_hit      <= 1'b0;
      dec_allocate <= 1'b0;
      dec_bypass   <= 1'b0;
      dec_no_alloc <= 1'b0;
      victim_way   <= '0;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) begin
        dec_hit      <= dec.hit;
        dec_allocate <= dec.allocate;
        dec_bypass   <= dec.bypass;
        dec_no_alloc <= dec.no_alloc;
        victim_way   <= dec.way;
      end
    end
  end

  // R1: one-cycle decision latency
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);
  // R2: outcomes are exclusive
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !(dec_allocate && (dec_bypass || dec_hit)));
  // R3: allocation never lands in a way locked at request time
  a_r3_no_locked_fill: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_allocate) |-> ((($past(lock_mask) >> victim_way) & 4'b0001) == 4'b0000));
  // R4: an empty unlocked way is taken before a valid one
  a_r4_empty_first: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_allocate && $past(|(~way_valid & ~lock_mask)))
      |-> ((($past(way_valid) >> victim_way) & 4'b0001) == 4'b0000));
  // R7: data traffic in fetch-only mode never allocates
  a_r7_data_bypass: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && fetch_only && !req_is_fetch) |-> (dec_bypass && !dec_allocate));
  // R8: no-allocate only as a bypass
  a_r8_noalloc_bypass: assert property (@(posedge clk) disable iff (rst)
    dec_no_alloc |-> (dec_bypass && !dec_hit));
  // R2: the tag compare delivers at most one hit way
  a_r2_hit_onehot: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_way));
endmodule

// File: tb/cache_way_alloc_bench.sv
module cache_way_alloc_bench;
  localparam int SET_W = 6;
  localparam int SETS  = 1 << SET_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [SET_W-1:0] req_set = '0;
  logic             req_is_fetch = 1'b0;
  logic [3:0]       hit_way = '0;
  logic [3:0]       way_valid = '0;
  logic [3:0]       lock_mask = '0;
  logic             fetch_only = 1'b0;
  logic             dec_valid, dec_hit, dec_allocate, dec_bypass, dec_no_alloc;
  logic [1:0]       victim_way;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_tree [SETS];

  always #10 clk = ~clk;

  cache_way_alloc #(.SET_W(SET_W)) u_cache_way_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
    .req_is_fetch(req_is_fetch), .hit_way(hit_way), .way_valid(way_valid),
    .lock_mask(lock_mask), .fetch_only(fetch_only), .dec_valid(dec_valid),
    .dec_hit(dec_hit), .dec_allocate(dec_allocate), .dec_bypass(dec_bypass),
    .dec_no_alloc(dec_no_alloc), .victim_way(victim_way)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] low_bit(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [1:0] m_target(input logic [2:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] m_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  // caller is at a falling edge; result checked one cycle later
  task automatic send(input int s, input logic f, input logic [3:0] h,
                      input logic [3:0] v, input logic [3:0] l, input logic io,
                      input int want_way, input string tag);
    logic e_hit, e_alloc, e_byp, e_noa, touch;
    logic [1:0] e_way, tw;
    logic [3:0] empty;
    e_hit = |h; e_alloc = 0; e_byp = 0; e_noa = 0; e_way = 0; touch = 0;
    if (io && !f) begin
      e_byp = 1; e_way = e_hit ? low_bit(h) : 2'd0;           // R7
    end else if (e_hit) begin
      e_way = low_bit(h); touch = 1;                          // R2
    end else if (l != 4'hF) begin
      e_alloc = 1; touch = 1;
      empty = ~v & ~l;
      tw = m_target(m_tree[s]);
      if (empty != 0)  e_way = low_bit(empty);                // R4
      else if (!l[tw]) e_way = tw;                            // R5
      else             e_way = low_bit(~l);                   // R3
    end else begin
      e_byp = 1; e_noa = 1;                                   // R8
    end
    req_valid = 1; req_set = SET_W'(s); req_is_fetch = f; hit_way = h;
    way_valid = v; lock_mask = l; fetch_only = io;
    @(negedge clk);
    chk({tag, " R1 valid"}, int'(dec_valid), 1);
    chk({tag, " hit"}, int'(dec_hit), int'(e_hit));
    chk({tag, " allocate"}, int'(dec_allocate), int'(e_alloc));
    chk({tag, " bypass"}, int'(dec_bypass), int'(e_byp));
    chk({tag, " no_alloc"}, int'(dec_no_alloc), int'(e_noa));
    chk({tag, " way"}, int'(victim_way), int'(e_way));
    if (want_way >= 0) chk({tag, " directed way"}, int'(victim_way), want_way);
    if (touch) m_tree[s] = m_touch(m_tree[s], e_way);         // R6, R10
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < SETS; i++) m_tree[i] = 3'b000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset dec_valid", int'(dec_valid), 0);
    // R5 tree walk from reset, all valid, no locks
    send(5, 1, 4'h0, 4'hF, 4'h0, 0, 0, "R5 first miss");
    send(5, 1, 4'h0, 4'hF, 4'h0, 0, 2, "R6 after way0 fill");
    // R3 tree names locked way1 -> lowest unlocked way0
    send(5, 1, 4'h0, 4'hF, 4'h2, 0, 0, "R3 locked target fallback");
    // R7 data miss in fetch-only mode leaves tree alone
    send(5, 0, 4'h0, 4'hF, 4'h0, 1, 0, "R7 data bypass");
    send(5, 1, 4'h0, 4'hF, 4'h0, 1, 3, "R7 fetch after data");
    // R8 all locked
    send(5, 1, 4'h0, 4'hF, 4'hF, 0, 0, "R8 all locked");
    // R4 empty unlocked way preferred
    send(5, 1, 4'h0, 4'hA, 4'h1, 0, 2, "R4 empty first");
    // R9 hit on locked way, then unlock on next request
    send(5, 1, 4'h1, 4'hF, 4'h1, 0, 0, "R9 locked hit");
    send(5, 0, 4'h0, 4'hF, 4'hE, 0, 0, "R9 new mask applies");
    // R10 neighbouring sets independent
    send(7, 1, 4'h0, 4'hF, 4'h0, 0, 0, "R10 set7 fill");
    send(8, 1, 4'h0, 4'hF, 4'h0, 0, 0, "R10 set8 untouched");
    // R2 hit on way 3
    send(7, 0, 4'h8, 4'hF, 4'h0, 0, 3, "R2 hit way3");
    begin : rnd
      void'($urandom(32'd1234));
      for (int n = 0; n < 3000; n++) begin
        logic [3:0] h, v, l;
        int s;
        s = int'($urandom % 4);
        v = 4'($urandom);
        l = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
        h = 4'h0;
        if ($urandom % 2 == 0) begin
          h = 4'b0001 << ($urandom % 4);
          v = v | h;
        end
        send(s, 1'($urandom), h, v, l, ($urandom % 4 == 0), -1, "R6 random");
      end
    end
    req_valid = 0;
    @(negedge clk);
    chk("R1 idle dec_valid", int'(dec_valid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule